// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) copes with dependencies and redirects. It looks at the source indices of the instruction in decode and in execute, at the destination index and write enable held in each later pipeline register, at two class flags (load in execute, environment call in decode) and at the branch outcome produced in execute. From these it drives two operand bypass selects for the ALU and five pipeline controls: hold of the program counter, hold of the fetch/decode register, bubble into the decode/execute register, and squash of the fetch/decode and decode/execute registers. A bubble or squashed slot is meant to be loaded as `addi x0, x0, 0` with every write enable cleared.

The logic is purely combinational. The control decision is an enumerated action chosen among four values: `ACT_FLOW` (everything advances), `ACT_HOLD_LOAD` (a load result is needed by the very next instruction), `ACT_HOLD_CALL` (an environment call waits for its argument registers) and `ACT_SQUASH` (a taken branch). The selection runs in fixed order: a taken branch moves to `ACT_SQUASH` whatever else is pending; otherwise a pending call interlock moves to `ACT_HOLD_CALL`; otherwise a load-use hit moves to `ACT_HOLD_LOAD`; otherwise the action falls back to `ACT_FLOW`. An environment call reads its argument registers through the register file only, so it waits until any older writer of them has left the memory stage; the register file is assumed to pass a writeback value through to a same-cycle read.

Top module: `hz_ctrl`

## Requirements
- R1: Bypass select encoding is 2'b00 register file, 2'b01 writeback-stage value, 2'b10 memory-stage value; an execute source equal to the memory-stage destination selects 2'b10.
- R2: An execute source that misses the memory stage but equals the writeback-stage destination selects 2'b01; when both stages match, 2'b10 wins.
- R3: A stage whose destination is x0 or whose write enable is low never produces a bypass, a load-use hold or a call hold.
- R4: When execute holds a load whose destination equals a used decode source, pc_hold, ifid_hold and idex_bubble are 1 and both squash outputs are 0.
- R5: An environment call in decode holds (pc_hold, ifid_hold, idex_bubble at 1) while the execute or memory stage writes x10 or x17, even though a bypass path exists; a writer already in writeback causes no hold.
- R6: A writer of x17 directly ahead of an environment call costs exactly two held cycles; with two unrelated instructions between them the call is not held.
- R7: A taken branch in execute sets ifid_flush and idex_flush to 1 and pc_hold, ifid_hold, idex_bubble to 0.
- R8: A taken branch overrides any hold requested in the same cycle.
- R9: With no taken branch and no interlock all five pipeline controls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source index of the decode instruction |
| id_rs2 | input | 5 | Second source index of the decode instruction |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_syscall | input | 1 | Decode instruction is an environment call |
| ex_rs1 | input | 5 | First source index of the execute instruction |
| ex_rs2 | input | 5 | Second source index of the execute instruction |
| ex_rd | input | 5 | Destination index of the execute instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_br_taken | input | 1 | Branch in execute is taken |
| mem_rd | input | 5 | Destination index in the execute/memory register |
| mem_wr_en | input | 1 | Write enable in the execute/memory register |
| wb_rd | input | 5 | Destination index in the memory/writeback register |
| wb_wr_en | input | 1 | Write enable in the memory/writeback register |
| fwd_a | output | 2 | Bypass select for the first ALU operand |
| fwd_b | output | 2 | Bypass select for the second ALU operand |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| ifid_flush | output | 1 | Squash the fetch/decode register |
| idex_flush | output | 1 | Squash the decode/execute register |

## Verification
The hardest situation to reach is an environment call meeting an argument writer at each distance in turn, because that distance only changes as bubbles drain through the later stages. The stimulus replays that drain cycle by cycle, writer in execute, then in memory behind a bubble, then in writeback, and counts the held cycles, then repeats it with two unrelated instructions in between. Around this, sweeps over indices drawn from {x0, x1, x2, x10, x17} with every enable, class and branch combination cover the priority orderings, including a taken branch colliding with both kinds of hold.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_REGFILE = 2'b00,
        FWD_WB      = 2'b01,
        FWD_MEM     = 2'b10
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ACT_FLOW,
        ACT_HOLD_LOAD,
        ACT_HOLD_CALL,
        ACT_SQUASH
    } hz_act_e;

endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    sel
);
    import hz_pkg::*;

    localparam logic [AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    assign mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
    assign wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

    always_comb begin
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_REGFILE;
    end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
    parameter int AW      = 5,
    parameter int ARG_REG = 10,
    parameter int FN_REG  = 17
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_rs1_used,
    input  logic          id_rs2_used,
    input  logic          id_is_syscall,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wr_en,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wr_en,
    output logic          load_hit,
    output logic          call_hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;
    localparam logic [AW-1:0] ARG_IDX  = AW'(ARG_REG);
    localparam logic [AW-1:0] FN_IDX   = AW'(FN_REG);

    logic ex_live;
    logic mem_live;
    logic ex_arg;
    logic mem_arg;

    assign ex_live  = ex_wr_en  && (ex_rd  != ZERO_REG);
    assign mem_live = mem_wr_en && (mem_rd != ZERO_REG);

    assign load_hit = ex_live && ex_is_load &&
                      ((id_rs1_used && (id_rs1 == ex_rd)) ||
                       (id_rs2_used && (id_rs2 == ex_rd)));

    assign ex_arg   = ex_live  && ((ex_rd  == ARG_IDX) || (ex_rd  == FN_IDX));
    assign mem_arg  = mem_live && ((mem_rd == ARG_IDX) || (mem_rd == FN_IDX));
    assign call_hit = id_is_syscall && (ex_arg || mem_arg);
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter (
    input  logic ex_br_taken,
    input  logic load_hit,
    input  logic call_hit,
    output logic pc_hold,
    output logic ifid_hold,
    output logic idex_bubble,
    output logic ifid_flush,
    output logic idex_flush
);
    import hz_pkg::*;

    hz_act_e act;

    always_comb begin
        if (ex_br_taken)   act = ACT_SQUASH;
        else if (call_hit) act = ACT_HOLD_CALL;
        else if (load_hit) act = ACT_HOLD_LOAD;
        else               act = ACT_FLOW;
    end

    always_comb begin
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        idex_bubble = 1'b0;
        ifid_flush  = 1'b0;
        idex_flush  = 1'b0;
        unique case (act)
            ACT_FLOW: begin
            end
            ACT_HOLD_LOAD, ACT_HOLD_CALL: begin
                pc_hold     = 1'b1;
                ifid_hold   = 1'b1;
                idex_bubble = 1'b1;
            end
            ACT_SQUASH: begin
                ifid_flush  = 1'b1;
                idex_flush  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
    parameter int AW      = 5,
    parameter int ARG_REG = 10,
    parameter int FN_REG  = 17
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_rs1_used,
    input  logic          id_rs2_used,
    input  logic          id_is_syscall,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wr_en,
    input  logic          ex_is_load,
    input  logic          ex_br_taken,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wr_en,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble,
    output logic          ifid_flush,
    output logic          idex_flush
);
    localparam int NOPS = 2;

    logic [AW-1:0] op_src [NOPS];
    logic [1:0]    op_sel [NOPS];
    logic          load_hit;
    logic          call_hit;

    assign op_src[0] = ex_rs1;
    assign op_src[1] = ex_rs2;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hz_fwd_unit #(.AW(AW)) u_fwd (
            .src    (op_src[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_wr_en),
            .wb_rd  (wb_rd),
            .wb_we  (wb_wr_en),
            .sel    (op_sel[g])
        );
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    hz_interlock #(.AW(AW), .ARG_REG(ARG_REG), .FN_REG(FN_REG)) u_lock (
        .id_rs1        (id_rs1),
        .id_rs2        (id_rs2),
        .id_rs1_used   (id_rs1_used),
        .id_rs2_used   (id_rs2_used),
        .id_is_syscall (id_is_syscall),
        .ex_rd         (ex_rd),
        .ex_wr_en      (ex_wr_en),
        .ex_is_load    (ex_is_load),
        .mem_rd        (mem_rd),
        .mem_wr_en     (mem_wr_en),
        .load_hit      (load_hit),
        .call_hit      (call_hit)
    );

    hz_arbiter u_arb (
        .ex_br_taken (ex_br_taken),
        .load_hit    (load_hit),
        .call_hit    (call_hit),
        .pc_hold     (pc_hold),
        .ifid_hold   (ifid_hold),
        .idex_bubble (idex_bubble),
        .ifid_flush  (ifid_flush),
        .idex_flush  (idex_flush)
    );
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
    parameter int AW      = 5,
    parameter int ARG_REG = 10,
    parameter int FN_REG  = 17
) (
    input logic [AW-1:0] id_rs1,
    input logic [AW-1:0] id_rs2,
    input logic          id_rs1_used,
    input logic          id_rs2_used,
    input logic          id_is_syscall,
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rs2,
    input logic [AW-1:0] ex_rd,
    input logic          ex_wr_en,
    input logic          ex_is_load,
    input logic          ex_br_taken,
    input logic [AW-1:0] mem_rd,
    input logic          mem_wr_en,
    input logic [AW-1:0] wb_rd,
    input logic          wb_wr_en,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          idex_bubble,
    input logic          ifid_flush,
    input logic          idex_flush
);
    localparam logic [AW-1:0] ZERO_REG = '0;
    localparam logic [AW-1:0] FN_IDX   = AW'(FN_REG);

    always_comb begin
        // R1
        fwd_code_valid_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
        // R3
        fwd_mem_source_chk: assert (fwd_a != 2'b10 ||
            (mem_wr_en && mem_rd != ZERO_REG && mem_rd == ex_rs1));
        // R7
        branch_squash_chk: assert (!ex_br_taken || (ifid_flush && idex_flush));
        // R8
        squash_over_hold_chk: assert (!ifid_flush || (!pc_hold && !ifid_hold && !idex_bubble));
        // R4
        hold_consistent_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
        // R5
        call_fn_hold_chk: assert (!(id_is_syscall && mem_wr_en && mem_rd == FN_IDX && !ex_br_taken)
                                  || pc_hold);
    end
endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW), .ARG_REG(ARG_REG), .FN_REG(FN_REG)) u_chk (.*);

// File: tb/hz_ctrl_tb.sv
module hz_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
    logic [4:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic id_rs1_used = 1'b0, id_rs2_used = 1'b0, id_is_syscall = 1'b0;
    logic ex_wr_en = 1'b0, ex_is_load = 1'b0, ex_br_taken = 1'b0;
    logic mem_wr_en = 1'b0, wb_wr_en = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hz_ctrl u_dut (.*);

    function automatic logic [4:0] pick(int i);
        case (i)
            0: return 5'd0;
            1: return 5'd1;
            2: return 5'd2;
            3: return 5'd10;
            default: return 5'd17;
        endcase
    endfunction

    function automatic logic [1:0] exp_fwd(logic [4:0] s);
        if (mem_wr_en && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_wr_en && wb_rd != 0 && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [4:0] ctl();
        return {pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush};
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        @(posedge clk);
        id_rs1 = 0; id_rs2 = 0; id_rs1_used = 0; id_rs2_used = 0; id_is_syscall = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wr_en = 0; ex_is_load = 0; ex_br_taken = 0;
        mem_rd = 0; mem_wr_en = 0; wb_rd = 0; wb_wr_en = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int stalls;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        idle();
        step();
        // R9: idle pipeline after reset
        check("R9 reset idle controls", ctl(), 5'b00000);
        check("R1 reset idle bypass", {1'b0, fwd_a, fwd_b}, 5'b00000);

        // R1 R2 R3: bypass sweep
        for (int a = 0; a < 5; a++)
            for (int m = 0; m < 5; m++)
                for (int mw = 0; mw < 2; mw++)
                    for (int w = 0; w < 5; w++)
                        for (int ww = 0; ww < 2; ww++) begin
                            idle();
                            ex_rs1 = pick(a); ex_rs2 = pick(4 - a);
                            mem_rd = pick(m); mem_wr_en = mw[0];
                            wb_rd = pick(w); wb_wr_en = ww[0];
                            step();
                            check("R1 R2 R3 bypass operand a", {3'b0, fwd_a}, {3'b0, exp_fwd(ex_rs1)});
                            check("R1 R2 R3 bypass operand b", {3'b0, fwd_b}, {3'b0, exp_fwd(ex_rs2)});
                        end

        // R3 R4 R5 R7 R8 R9: control sweep
        for (int s = 0; s < 5; s++)
            for (int u = 0; u < 2; u++)
                for (int c = 0; c < 2; c++)
                    for (int e = 0; e < 5; e++)
                        for (int ew = 0; ew < 2; ew++)
                            for (int ld = 0; ld < 2; ld++)
                                for (int m = 0; m < 5; m++)
                                    for (int mw = 0; mw < 2; mw++)
                                        for (int t = 0; t < 2; t++) begin
                                            logic lh, ch;
                                            logic [4:0] exp;
                                            string tag;
                                            idle();
                                            id_rs1 = pick(s); id_rs1_used = u[0];
                                            id_rs2 = 5'd2; id_rs2_used = 1'b1;
                                            id_is_syscall = c[0];
                                            ex_rd = pick(e); ex_wr_en = ew[0]; ex_is_load = ld[0];
                                            mem_rd = pick(m); mem_wr_en = mw[0];
                                            ex_br_taken = t[0];
                                            wb_rd = 5'd17; wb_wr_en = 1'b1;
                                            lh = ex_wr_en && ex_rd != 0 && ex_is_load &&
                                                 ((id_rs1_used && id_rs1 == ex_rd) || ex_rd == 5'd2);
                                            ch = id_is_syscall &&
                                                 ((ex_wr_en && (ex_rd == 5'd10 || ex_rd == 5'd17)) ||
                                                  (mem_wr_en && (mem_rd == 5'd10 || mem_rd == 5'd17)));
                                            if (ex_br_taken) begin
                                                exp = 5'b00011;
                                                tag = (lh || ch) ? "R8 squash beats hold" : "R7 taken squash";
                                            end else if (ch || lh) begin
                                                exp = 5'b11100;
                                                tag = ch ? "R5 call interlock" : "R4 load-use hold";
                                            end else begin
                                                exp = 5'b00000;
                                                tag = "R9 R3 free flow";
                                            end
                                            step();
                                            check(tag, ctl(), exp);
                                        end

        // R6: writer of x17 directly ahead of the call, drained stage by stage
        stalls = 0;
        idle(); id_is_syscall = 1; ex_rd = 17; ex_wr_en = 1; ex_rs1 = 10;
        step(); if (pc_hold) stalls++;
        check("R5 call held although bypass exists", {4'b0, pc_hold}, 5'b00001);
        idle(); id_is_syscall = 1; mem_rd = 17; mem_wr_en = 1;
        step(); if (pc_hold) stalls++;
        idle(); id_is_syscall = 1; wb_rd = 17; wb_wr_en = 1;
        step(); if (pc_hold) stalls++;
        check("R5 writeback writer no hold", ctl(), 5'b00000);
        check("R6 two held cycles", 5'(stalls), 5'd2);

        // R6: two unrelated instructions in between
        idle(); id_is_syscall = 1;
        ex_rd = 5; ex_wr_en = 1; mem_rd = 6; mem_wr_en = 1; wb_rd = 17; wb_wr_en = 1;
        step();
        check("R6 separated call not held", ctl(), 5'b00000);

        // R4: load-use through second source
        idle(); id_rs2 = 9; id_rs2_used = 1; ex_rd = 9; ex_wr_en = 1; ex_is_load = 1;
        step();
        check("R4 load-use on second source", ctl(), 5'b11100);
        // R3: same load into x0 has no effect
        idle(); id_rs2 = 0; id_rs2_used = 1; ex_rd = 0; ex_wr_en = 1; ex_is_load = 1;
        step();
        check("R3 load into x0 no hold", ctl(), 5'b00000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule